// File: doc/BRIEF.md
# Code-Protect-Aware Program Memory Checksum

This block computes a 16-bit checksum over a stream of program-memory words. It adds each word into a running total, then adds a masked configuration word that closes the stream. Only the low 16 bits of the total are kept. An external reader fetches the memory and chooses the address range. It presents the words on a valid/ready interface and flags the configuration word as the last beat.

Two choices are made at the start of each run. The first is the device variant. The compact variant masks the configuration word with 0x005F and adds a fixed bias of 0xFFA0. The standard variant masks it with 0x015F and adds no bias. The second choice is the protect setting, which selects how each memory word is transformed before it is added. The protect setting comes from the three processor-mode bits presented at start, unless an override input takes control. When protected, a word is replaced by the bitwise XNOR of its two bytes, written into both bytes. The result is held after the run until the next start pulse.

Top module: `pmem_checksum`

## Requirements
- R1: After reset, `sum_o` is 0x0000 and both `done_o` and `in_ready_o` are low.
- R2: A `start_i` pulse clears `sum_o` to 0x0000 and `done_o` to low at the next edge, and `in_ready_o` is high from that edge. A start pulse during a run abandons that run.
- R3: When not protected, each non-last accepted word is added to the total unchanged, modulo 2^16.
- R4: When protected, each non-last accepted word with high byte H and low byte L contributes {~(H^L), ~(H^L)}.
- R5: With `variant_i` = 1 (compact), the last beat adds (word & 0x005F) + 0xFFA0.
- R6: With `variant_i` = 0 (standard), the last beat adds word & 0x015F and no bias.
- R7: At the start pulse, the protect setting is captured as `prot_sel_i` when `prot_ovr_i` is high, and otherwise as (`pm_i` == 3'b000). Changes to these inputs after the start pulse have no effect on the run.
- R8: The last beat is never byte-transformed. `done_o` rises at the same edge that adds the last beat into `sum_o`.
- R9: Once `done_o` is high, `in_ready_o` is low, further beats are ignored, and `sum_o` and `done_o` hold until the next start.
- R10: A beat is accepted only in a cycle where `in_valid_i` and `in_ready_o` are both high. Idle cycles, and beats offered before any start, leave `sum_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the total and begins a run |
| variant_i | input | 1 | 1 = compact variant (mask 0x005F with bias 0xFFA0), 0 = standard variant (mask 0x015F) |
| pm_i | input | 3 | Processor-mode bits; 3'b000 selects protected mode |
| prot_ovr_i | input | 1 | When high, `prot_sel_i` sets the protect setting instead of `pm_i` |
| prot_sel_i | input | 1 | Protect value used when the override is high |
| in_valid_i | input | 1 | Word beat valid |
| in_ready_o | output | 1 | Block accepts a beat this cycle |
| in_data_i | input | 16 | Memory word, or configuration word on the last beat |
| in_last_i | input | 1 | Marks the configuration word |
| sum_o | output | 16 | Running and final checksum |
| done_o | output | 1 | High once the last beat has been added |

## Verification
The bench builds the block with its default parameters: 16-bit words, standard mask 0x015F, compact mask 0x005F and bias 0xFFA0. With these values the known reference totals of an erased 2048-word image are in reach. These are 0xF7FF and 0xF95F in microprocessor mode, and 0xF7AF and 0xF80F in protected mode, each checked against the full stream. Short hand-computed streams cover the following cases:
- the byte-XNOR transform;
- both directions of the override;
- a wrap of the total past 0xFFFF;
- a run that contains only the configuration word.

// File: rtl/pmem_checksum_pkg.sv
package pmem_checksum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } pmc_state_e;

   localparam int unsigned PM_BITS = 3;
   localparam logic [PM_BITS-1:0] PM_LOCKED = 3'b000;

   function automatic logic pmc_protect(input logic ovr, input logic sel,
                                        input logic [PM_BITS-1:0] pm);
      return ovr ? sel : (pm == PM_LOCKED);
   endfunction

endpackage

// File: rtl/pmc_word_xform.sv
module pmc_word_xform #(
   parameter int unsigned W = 16
) (
   input  logic         protect,
   input  logic [W-1:0] word,
   output logic [W-1:0] val
);
   localparam int unsigned H = W / 2;

   if ((W % 2) != 0 || W < 4) begin : g_bad_width
      $error("pmc_word_xform: W must be even and at least 4");
   end

   logic [H-1:0] fold;

   for (genvar g = 0; g < H; g++) begin : g_fold
      assign fold[g] = ~(word[g+H] ^ word[g]);
   end

   assign val = protect ? {fold, fold} : word;

endmodule

// File: rtl/pmc_cfg_mask.sv
module pmc_cfg_mask #(
   parameter int unsigned    W        = 16,
   parameter logic [W-1:0]   STD_MASK = 16'h015F,
   parameter logic [W-1:0]   CMP_MASK = 16'h005F,
   parameter logic [W-1:0]   CMP_BIAS = 16'hFFA0
) (
   input  logic         compact,
   input  logic [W-1:0] cfg,
   output logic [W-1:0] addend
);
   logic [W-1:0] cmp_term;

   if (CMP_BIAS == '0) begin : g_no_bias
      assign cmp_term = cfg & CMP_MASK;
   end else begin : g_bias
      assign cmp_term = (cfg & CMP_MASK) + CMP_BIAS;
   end

   assign addend = compact ? cmp_term : (cfg & STD_MASK);

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add_en,
   input  logic [W-1:0] addend,
   output logic [W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sum <= '0;
      else if (clr)     sum <= '0;
      else if (add_en)  sum <= sum + addend;
   end

endmodule

// File: rtl/pmem_checksum.sv
module pmem_checksum
   import pmem_checksum_pkg::*;
#(
   parameter int unsigned      W        = 16,
   parameter logic [W-1:0]     STD_MASK = 16'h015F,
   parameter logic [W-1:0]     CMP_MASK = 16'h005F,
   parameter logic [W-1:0]     CMP_BIAS = 16'hFFA0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               variant_i,
   input  logic [PM_BITS-1:0] pm_i,
   input  logic               prot_ovr_i,
   input  logic               prot_sel_i,
   input  logic               in_valid_i,
   output logic               in_ready_o,
   input  logic [W-1:0]       in_data_i,
   input  logic               in_last_i,
   output logic [W-1:0]       sum_o,
   output logic               done_o
);
   if (W % 8 != 0) begin : g_bad_w
      $error("pmem_checksum: W must be a whole number of bytes");
   end

   pmc_state_e   state_q;
   logic         prot_q;
   logic         cmp_q;
   logic         beat;
   logic [W-1:0] word_val;
   logic [W-1:0] cfg_val;
   logic [W-1:0] addend;

   assign in_ready_o = (state_q == ST_RUN);
   assign done_o     = (state_q == ST_DONE);
   assign beat       = in_valid_i && in_ready_o && !start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         prot_q  <= 1'b0;
         cmp_q   <= 1'b0;
      end else if (start_i) begin
         state_q <= ST_RUN;
         prot_q  <= pmc_protect(prot_ovr_i, prot_sel_i, pm_i);
         cmp_q   <= variant_i;
      end else if (beat && in_last_i) begin
         state_q <= ST_DONE;
      end
   end

   pmc_word_xform #(.W(W)) u_xform (
      .protect (prot_q),
      .word    (in_data_i),
      .val     (word_val)
   );

   pmc_cfg_mask #(
      .W(W), .STD_MASK(STD_MASK), .CMP_MASK(CMP_MASK), .CMP_BIAS(CMP_BIAS)
   ) u_cfg (
      .compact (cmp_q),
      .cfg     (in_data_i),
      .addend  (cfg_val)
   );

   assign addend = in_last_i ? cfg_val : word_val;

   pmc_accum #(.W(W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_i),
      .add_en (beat),
      .addend (addend),
      .sum    (sum_o)
   );

   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (sum_o == '0) && !done_o && in_ready_o); // R2
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o && $stable(sum_o)); // R9
   AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !in_ready_o); // R9
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid_i && !start_i) |=> $stable(sum_o)); // R10
   AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(in_valid_i && in_ready_o && in_last_i)); // R8
   AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(prot_q) && $stable(cmp_q)); // R7

endmodule

// File: tb/sim_pmem_checksum.sv
module sim_pmem_checksum;

   typedef struct packed {
      logic        variant;
      logic [2:0]  pm;
      logic        ovr;
      logic        sel;
      logic [11:0] nwords;
      logic [15:0] base;
      logic [15:0] step;
      logic [15:0] cfg;
      logic [15:0] expect_sum;
      logic [3:0]  rq;
   } vec_t;

   // Requirement numbers in the rq field: R3, R4, R5, R6, R7, R8
   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'b111, 1'b0, 1'b0, 12'd2048, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hF7FF, 4'd5},
      '{1'b0, 3'b111, 1'b0, 1'b0, 12'd2048, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hF95F, 4'd6},
      '{1'b0, 3'b000, 1'b0, 1'b0, 12'd2048, 16'hFFFF, 16'h0000, 16'hFEAF, 16'hF80F, 4'd7},
      '{1'b1, 3'b000, 1'b0, 1'b0, 12'd2048, 16'hFFFF, 16'h0000, 16'hFEAF, 16'hF7AF, 4'd5},
      '{1'b0, 3'b000, 1'b0, 1'b0, 12'd2,    16'h1234, 16'h0000, 16'h0000, 16'hB3B2, 4'd4},
      '{1'b0, 3'b111, 1'b0, 1'b0, 12'd2,    16'h1234, 16'h0000, 16'h0000, 16'h2468, 4'd3},
      '{1'b0, 3'b111, 1'b1, 1'b1, 12'd2,    16'h1234, 16'h0000, 16'h0000, 16'hB3B2, 4'd7},
      '{1'b0, 3'b000, 1'b1, 1'b0, 12'd2,    16'h1234, 16'h0000, 16'h0000, 16'h2468, 4'd7},
      '{1'b0, 3'b111, 1'b0, 1'b0, 12'd1,    16'hFFFF, 16'h0000, 16'hFFFF, 16'h015E, 4'd6},
      '{1'b0, 3'b101, 1'b0, 1'b0, 12'd3,    16'h0100, 16'h0101, 16'h0010, 16'h0613, 4'd3},
      '{1'b0, 3'b000, 1'b0, 1'b0, 12'd3,    16'h0100, 16'h0101, 16'h0010, 16'hFB08, 4'd4},
      '{1'b1, 3'b110, 1'b0, 1'b0, 12'd0,    16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd8}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        variant_i = 1'b0;
   logic [2:0]  pm_i = 3'b111;
   logic        prot_ovr_i = 1'b0;
   logic        prot_sel_i = 1'b0;
   logic        in_valid_i = 1'b0;
   logic [15:0] in_data_i = 16'h0000;
   logic        in_last_i = 1'b0;
   logic        in_ready_o;
   logic [15:0] sum_o;
   logic        done_o;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   pmem_checksum u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
      .pm_i(pm_i), .prot_ovr_i(prot_ovr_i), .prot_sel_i(prot_sel_i),
      .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
      .in_last_i(in_last_i), .sum_o(sum_o), .done_o(done_o)
   );

   task automatic chk(input logic ok, input string rq,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic pulse_start(input logic cmp, input logic [2:0] pm,
                              input logic ovr, input logic sel);
      @(negedge clk);
      start_i = 1'b1; variant_i = cmp; pm_i = pm;
      prot_ovr_i = ovr; prot_sel_i = sel;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic send_words(input int n, input logic [15:0] base,
                             input logic [15:0] step);
      for (int i = 0; i < n; i++) begin
         if (i % 5 == 4) begin
            in_valid_i = 1'b0; in_data_i = 16'hFFFF; in_last_i = 1'b0;
            @(negedge clk);
         end
         in_valid_i = 1'b1;
         in_data_i  = base + 16'(i) * step;
         in_last_i  = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic send_last(input logic [15:0] cfg);
      in_valid_i = 1'b1; in_data_i = cfg; in_last_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0; in_last_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 16'h0001, 16'h0000);
      finish_run();
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sum_o == 16'h0000, "R1 sum", sum_o, 16'h0000);
      chk(done_o == 1'b0, "R1 done", {15'd0, done_o}, 16'h0000);
      chk(in_ready_o == 1'b0, "R1 ready", {15'd0, in_ready_o}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: beats offered before any start are ignored
      in_valid_i = 1'b1; in_data_i = 16'h5A5A; in_last_i = 1'b1;
      repeat (3) @(negedge clk);
      in_valid_i = 1'b0; in_last_i = 1'b0;
      chk(sum_o == 16'h0000 && !done_o, "R10 idle beats", sum_o, 16'h0000);

      // Table of vectors
      for (int v = 0; v < NV; v++) begin
         pulse_start(VEC[v].variant, VEC[v].pm, VEC[v].ovr, VEC[v].sel);
         send_words(int'(VEC[v].nwords), VEC[v].base, VEC[v].step);
         chk(done_o == 1'b0, "R8 done before last", {15'd0, done_o}, 16'h0000);
         send_last(VEC[v].cfg);
         chk(done_o == 1'b1, "R8 done after last", {15'd0, done_o}, 16'h0001);
         chk(sum_o == VEC[v].expect_sum, $sformatf("R%0d vector %0d", VEC[v].rq, v),
             sum_o, VEC[v].expect_sum);
      end

      // R9: beats after done are ignored, state held
      held = sum_o;
      in_valid_i = 1'b1; in_data_i = 16'h1111; in_last_i = 1'b0;
      repeat (2) @(negedge clk);
      in_last_i = 1'b1;
      @(negedge clk);
      in_valid_i = 1'b0; in_last_i = 1'b0;
      chk(sum_o == held, "R9 sum held", sum_o, held);
      chk(done_o && !in_ready_o, "R9 done held, not ready",
          {14'd0, done_o, in_ready_o}, 16'h0002);

      // R2: restart clears
      pulse_start(1'b0, 3'b111, 1'b0, 1'b0);
      chk(sum_o == 16'h0000, "R2 clear sum", sum_o, 16'h0000);
      chk(!done_o && in_ready_o, "R2 flags", {14'd0, done_o, in_ready_o}, 16'h0001);

      // R2: a start in mid-run abandons the partial total
      send_words(2, 16'h4321, 16'h0001);
      pulse_start(1'b0, 3'b111, 1'b0, 1'b0);
      send_last(16'h0001);
      chk(sum_o == 16'h0001, "R2 mid-run restart", sum_o, 16'h0001);

      // R7: protect captured at start; later pm change has no effect
      pulse_start(1'b0, 3'b000, 1'b0, 1'b0);
      pm_i = 3'b111;
      send_words(1, 16'h1234, 16'h0000);
      send_last(16'h0000);
      chk(sum_o == 16'hD9D9, "R7 protect latched", sum_o, 16'hD9D9);

      finish_run();
   end

endmodule